// File: doc/BRIEF.md
# Multiplexed Display Scan Timer

This block sequences an eight-position multiplexed display. It takes a single-cycle oscillator tick enable, divides it by 64 in a pre-divider and steps a 3-bit multiplex counter on each pre-divider wrap. The counter drives a one-hot, active-high position select and doubles as the read address into the character store, so the segment pattern fetched always belongs to the position being lit. While the pre-divider sits in its final two counts before an advance, a blanking flag is raised and every select line is held low. This gives the segment drivers a clean gap at each position change.

A shutdown input puts the scan into a low-power idle. The display is blanked at once, both counters are cleared at the next clock edge and held at zero, and a display-full status that passes through the block is masked. The scan is controlled by a three-state machine. `SC_DRIVE` is the lit part of a position. `SC_GAP` is the two-count blanking window. `SC_OFF` is shutdown. Its transitions are as follows:
- drive-to-gap, taken on a tick at pre-divider count 61;
- gap-to-drive, taken on a tick at count 63, which also advances the position;
- any-to-off, taken whenever shutdown is high at a clock edge;
- off-to-drive, taken at the first edge with shutdown low.

Top module: `scan_timer_top`

## Requirements
- R1: Only clock edges with `tick_i` high advance the pre-divider. Position changes happen exactly once per 64 counted ticks, on the tick that takes the pre-divider from 63 to 0. Edges without a tick change no output.
- R2: `blank_o` is high while the pre-divider holds 62 or 63, which is the last two ticks before an advance. It is also high whenever `shutdown_i` is high or the machine is in `SC_OFF`. Otherwise it is low.
- R3: `char_sel_o` is one-hot and active high when not blanked. Bit k lights position k+1, and counter value 0 is position 1. It is all zeros whenever `blank_o` is high.
- R4: Positions advance in ascending order, 0 through 7, and the counter wraps from 7 back to 0.
- R5: `rd_addr_o` is the 3-bit multiplex counter value. It equals the index of the lit select bit and changes on the same edge as the position.
- R6: When `shutdown_i` is high, `blank_o` rises and `char_sel_o` clears in the same cycle with no register in the path. At the next edge both counters clear, and they stay at zero while shutdown persists.
- R7: `full_out_o` follows `full_in_i` while `shutdown_i` is low and is forced to 0 while `shutdown_i` is high.
- R8: When shutdown is released, the first clock edge moves `SC_OFF` to `SC_DRIVE` without counting a tick. The display stays blanked until that edge. The scan then resumes at position 1 with the pre-divider at 0.
- R9: An active-low `rst_n` asynchronously sets both counters to 0 and the machine to `SC_DRIVE`, so position 1 is lit right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oscillator tick enable, one clock wide |
| shutdown_i | input | 1 | Low-power shutdown request, active high |
| full_in_i | input | 1 | Display-full status from the write side |
| char_sel_o | output | 8 | One-hot position select, active high |
| rd_addr_o | output | 3 | Character store read address |
| blank_o | output | 1 | Segment blanking flag |
| full_out_o | output | 1 | Display-full status, masked in shutdown |

## Verification
The bench keeps an arithmetic count of accepted ticks. From that count alone it derives pre-divider phase, position, blanking and select for every cycle. A tick on every clock sweeps all 512 phase/position pairs and the 7-to-0 wrap, which separates off-by-one errors in the divide ratio and in the blanking window. A sparse pattern, one tick every third clock, shows whether idle edges are wrongly counted. Shutdown pulses of several lengths, placed mid-position and during a gap, together with toggling `full_in_i`, test the combinational masking, the clearing and the restart edge. A reset asserted mid-scan tests the asynchronous return to position 1.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        SC_OFF   = 2'd0,
        SC_DRIVE = 2'd1,
        SC_GAP   = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_prediv.sv
module scan_prediv #(
    parameter int DIV = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    output logic [$clog2(DIV)-1:0]   cnt,
    output logic                     wrap
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    assign wrap = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R1: an edge without a counted tick leaves the pre-divider unchanged
    a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/scan_mux_ctr.sv
module scan_mux_ctr #(
    parameter int NCHAR = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       step,
    output logic [$clog2(NCHAR)-1:0]   idx,
    output logic [NCHAR-1:0]           dec
);
    localparam int W = $clog2(NCHAR);
    localparam logic [W-1:0] LAST = W'(NCHAR - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (step)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    for (genvar k = 0; k < NCHAR; k++) begin : g_dec
        assign dec[k] = (idx == W'(k));
    end

    // R4: every advance moves to the next position in ascending order
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx != LAST) |=> (idx == W'($past(idx) + 1)));
    // R4: the last position wraps back to the first
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int DIV     = 64,
    parameter int GAP_LEN = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     shutdown,
    input  logic [$clog2(DIV)-1:0]   pre_cnt,
    output scan_state_e              state,
    output logic                     run,
    output logic                     gap_blank
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] GAP_ENTRY = W'(DIV - GAP_LEN - 1);
    localparam logic [W-1:0] GAP_FIRST = W'(DIV - GAP_LEN);
    localparam logic [W-1:0] PRE_LAST  = W'(DIV - 1);

    scan_state_e nxt;

    always_comb begin
        nxt = state;
        if (shutdown) begin
            nxt = SC_OFF;
        end else begin
            unique case (state)
                SC_OFF:   nxt = SC_DRIVE;
                SC_DRIVE: if (tick && pre_cnt == GAP_ENTRY) nxt = SC_GAP;
                SC_GAP:   if (tick && pre_cnt == PRE_LAST)  nxt = SC_DRIVE;
                default:  nxt = SC_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SC_DRIVE;
        else
            state <= nxt;
    end

    always_comb begin
        run       = (state != SC_OFF) && !shutdown;
        gap_blank = (state != SC_DRIVE);
    end

    // R2: the gap state coincides with the final pre-divider counts
    a_r2_gap_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_GAP) == (pre_cnt >= GAP_FIRST));
    // R6: shutdown at an edge leaves the pre-divider cleared
    a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (pre_cnt == '0));
    // R8: the first edge after release restarts without counting
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_OFF && !shutdown) |=> (state == SC_DRIVE && pre_cnt == '0));
endmodule

// File: rtl/scan_timer_top.sv
module scan_timer_top
    import scan_pkg::*;
#(
    parameter int DIV     = 64,
    parameter int NCHAR   = 8,
    parameter int GAP_LEN = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       shutdown_i,
    input  logic                       full_in_i,
    output logic [NCHAR-1:0]           char_sel_o,
    output logic [$clog2(NCHAR)-1:0]   rd_addr_o,
    output logic                       blank_o,
    output logic                       full_out_o
);
    localparam int PW = $clog2(DIV);
    localparam int AW = $clog2(NCHAR);

    logic [PW-1:0]    pre_cnt;
    logic             pre_wrap;
    logic             run;
    logic             gap_blank;
    logic [AW-1:0]    idx;
    logic [NCHAR-1:0] dec;
    scan_state_e      state;

    scan_fsm #(.DIV(DIV), .GAP_LEN(GAP_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .shutdown  (shutdown_i),
        .pre_cnt   (pre_cnt),
        .state     (state),
        .run       (run),
        .gap_blank (gap_blank)
    );

    scan_prediv #(.DIV(DIV)) u_prediv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .en    (run && tick_i),
        .cnt   (pre_cnt),
        .wrap  (pre_wrap)
    );

    scan_mux_ctr #(.NCHAR(NCHAR)) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .step  (pre_wrap),
        .idx   (idx),
        .dec   (dec)
    );

    always_comb begin
        blank_o    = shutdown_i || gap_blank;
        char_sel_o = blank_o ? '0 : dec;
        rd_addr_o  = idx;
        full_out_o = full_in_i && !shutdown_i;
    end

    // R3: at most one position is lit, and exactly one outside blanking
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o ? (char_sel_o == '0) : $onehot(char_sel_o));
    // R5: the lit position matches the read address
    a_r5_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |-> char_sel_o[rd_addr_o]);
    // R6: while shutdown holds, the position counter stays cleared
    a_r6_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> (rd_addr_o == '0));
    // R7: status is masked in shutdown
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |-> !full_out_o);
    // R9: the machine never holds an unused encoding
    a_r9_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {SC_OFF, SC_DRIVE, SC_GAP});
endmodule

// File: tb/scan_timer_top_test.sv
`timescale 1ns/1ps
module scan_timer_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       shutdown_i = 1'b0;
    logic       full_in_i = 1'b0;
    logic [7:0] char_sel_o;
    logic [2:0] rd_addr_o;
    logic       blank_o;
    logic       full_out_o;

    int checks = 0;
    int errors = 0;
    int n_ticks = 0;
    bit off_st = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_timer_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .shutdown_i (shutdown_i),
        .full_in_i  (full_in_i),
        .char_sel_o (char_sel_o),
        .rd_addr_o  (rd_addr_o),
        .blank_o    (blank_o),
        .full_out_o (full_out_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input logic sd, input logic fi);
        int pre, ch;
        bit blk;
        pre = n_ticks % 64;
        ch  = (n_ticks / 64) % 8;
        blk = sd || off_st || (pre >= 62);
        chk("R2 blank", int'(blank_o), int'(blk));
        chk("R3/R4 char_sel", int'(char_sel_o), blk ? 0 : (1 << ch));
        chk("R5 rd_addr", int'(rd_addr_o), ch);
        chk("R7 full_out", int'(full_out_o), int'(fi && !sd));
    endtask

    // one cycle: drive at falling edge, check, clock, update model
    task automatic step(input logic tk, input logic sd, input logic fi);
        tick_i = tk; shutdown_i = sd; full_in_i = fi;
        #1;
        check_all(sd, fi);
        @(posedge clk);
        #1;
        if (sd) begin
            off_st = 1'b1; n_ticks = 0;          // R6 clear at edge
        end else if (off_st) begin
            off_st = 1'b0;                       // R8 restart edge counts nothing
        end else if (tk) begin
            n_ticks++;                           // R1
        end
        @(negedge clk);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #12;
        @(negedge clk);
        // R9: reset state, position 1 lit
        chk("R9 reset char_sel", int'(char_sel_o), 1);
        chk("R9 reset blank", int'(blank_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4: tick every clock, full sweep plus wrap 7->0
        for (int i = 0; i < 600; i++) step(1'b1, 1'b0, i[4]);

        // R1: sparse ticks, idle edges must not count
        for (int i = 0; i < 300; i++) step(i % 3 == 0, 1'b0, i[0]);

        // R6 R7 R8: multi-cycle shutdown mid-position
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b1);

        // R6 R8: single-cycle shutdown inside a gap
        while (n_ticks % 64 != 62) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 1'b0);

        // R9: asynchronous reset mid-scan
        tick_i = 1'b0;
        #1;
        rst_n = 1'b0;
        #1;
        chk("R9 async reset char_sel", int'(char_sel_o), 1);
        chk("R9 async reset addr", int'(rd_addr_o), 0);
        n_ticks = 0; off_st = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule